// File: doc/BRIEF.md
# Small Integer Subset Execution Core

A multi-cycle, non-pipelined processor core that reads 32-bit instruction words over one synchronous memory port, decodes them and executes four kinds of operation. The first is a bitwise OR of a register with an immediate. The second is a conditional branch taken when a chosen bit of a register is clear. The third is a sign-extended halfword load that can write its computed address back to the base register. The fourth is an absolute jump that saves a return address. Data reads use the same port as instruction fetches. Only one access is in flight at a time.

The core holds 32 general registers, and register 0 always reads as zero. It keeps the address of the current instruction and a separate fetch pointer. The fetch pointer steps past an optional 32-bit immediate word that trails some instructions. Any encoding outside the subset raises a sticky illegal-instruction flag and halts the core until reset.

Top module: `mini_risc_core`

## Requirements
- R1: Reset clears every general register and drops the illegal flag. After reset, the first request fetches from the RESET_VEC parameter (default 0).
- R2: When bits [21:20] are not 3 and bits [21:15] equal 0x17, the register named in bits [31:27] receives the register named in bits [26:22] ORed with bits [14:0], zero-extended.
- R3: When bits [21:20] are not 3 and bits [21:15] equal 0x49, the core tests bit N of the register in bits [26:22], with N taken from bits [31:27]. If that bit is 0, the next fetch is from the branch's own address plus 4 times bits [14:0], sign-extended. Otherwise the next fetch is from the branch's address plus 4.
- R4: When bits [21:20] equal 3, bits [19:12] are the opcode. If bit 12 is set, the word after the instruction is read as a 32-bit immediate and the fetch pointer moves past it.
- R5: Opcode 0x2F in the long format writes the register in bits [26:22] ORed with the 32-bit immediate to the register in bits [31:27].
- R6: Opcodes 0x43 and 0x4B in the long format load a halfword from base (bits [26:22]) plus the immediate. The immediate is shifted left by one when bit 11 is set. Address bit 1 selects the lane: 0 picks data bits [31:16] and 1 picks bits [15:0]. The halfword is sign-extended into the register in bits [31:27].
- R7: When a halfword load has bit 15 set (opcode 0x4B) and its base is not register 0, the computed address is written to the base register. If the destination equals that base, the base ends up holding the address. Opcode 0x43 leaves the base unchanged.
- R8: Opcode 0x8B in the long format writes the address that follows the instruction and its immediate to the register in bits [31:27]. It then fetches from base (bits [26:22]) plus the immediate. When the link and base name the same nonzero register, the newly written link value serves as the base.
- R9: Writes to register 0 are dropped, so register 0 always reads as zero.
- R10: Any other opcode in either format sets the illegal output. The flag stays set and no further memory request is made until reset. An undefined long-format opcode does not fetch an immediate.
- R11: Each request is a single-cycle mem_req pulse carrying mem_addr. No new request is made until mem_valid has returned the data for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the read |
| mem_valid | input | 1 | Read data is present this cycle |
| mem_rdata | input | 32 | Read data word |
| illegal | output | 1 | Sticky undefined-instruction flag; core halted |

## Verification
The checker assumes that memory never raises mem_valid unless the core is waiting for data. It also assumes exactly one response arrives per request, one or more cycles after the pulse. The bench memory model answers each request exactly one cycle later and counts any request that overlaps an unanswered one. Every program the bench runs ends by jumping to an address whose word decodes as undefined. The halt can therefore be reached, and the final fetch address shows the value of the register used as the jump base.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);
  localparam int IMMW = 15;

  localparam logic [6:0] SOP_ORI  = 7'h17;
  localparam logic [6:0] SOP_BCLR = 7'h49;
  localparam logic [7:0] LOP_ORI  = 8'h2F;
  localparam logic [7:0] LOP_LDH  = 8'h43;
  localparam logic [7:0] LOP_LDHW = 8'h4B;
  localparam logic [7:0] LOP_JAL  = 8'h8B;

  typedef enum logic [3:0] {
    S_FETCH, S_IWAIT, S_DECODE, S_IMMREQ, S_IMMWAIT,
    S_EXEC, S_LDREQ, S_LDWAIT, S_LDWB, S_HALT
  } state_t;

  typedef enum logic [2:0] {
    OP_ORS, OP_BCLR, OP_ORL, OP_LDH, OP_JAL, OP_BAD
  } op_t;

  typedef struct packed {
    op_t             op;
    logic [RIDX-1:0] rd;
    logic [RIDX-1:0] rs;
    logic [IMMW-1:0] imm15;
    logic            has_imm;
    logic            scale;
    logic            wback;
  } dec_t;

  function automatic logic [XLEN-1:0] zext15(input logic [IMMW-1:0] k);
    return {{(XLEN-IMMW){1'b0}}, k};
  endfunction

  function automatic logic [XLEN-1:0] sext15(input logic [IMMW-1:0] k);
    return {{(XLEN-IMMW){k[IMMW-1]}}, k};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] here,
                                                  input logic [IMMW-1:0] off);
    return here + (sext15(off) << 2);
  endfunction

  function automatic logic [XLEN-1:0] load_ea(input logic [XLEN-1:0] base,
                                              input logic [XLEN-1:0] imm,
                                              input logic sc);
    return base + (sc ? (imm << 1) : imm);
  endfunction

  function automatic logic [XLEN-1:0] half_pick(input logic [XLEN-1:0] word,
                                                input logic a1);
    logic [15:0] h;
    h = a1 ? word[15:0] : word[31:16];
    return {{(XLEN-16){h[15]}}, h};
  endfunction

endpackage

// File: rtl/core_regfile.sv
module core_regfile
  import core_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int NR = NREG,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);

  logic [W-1:0] regs [NR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata = (raddr == '0) ? '0 : regs[raddr];

endmodule

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [XLEN-1:0] ir,
  output dec_t            dec
);

  logic       long_fmt;
  logic [6:0] sop;
  logic [7:0] lop;

  assign long_fmt = (ir[21:20] == 2'd3);
  assign sop      = ir[21:15];
  assign lop      = ir[19:12];

  always_comb begin
    dec.rd      = ir[31:27];
    dec.rs      = ir[26:22];
    dec.imm15   = ir[14:0];
    dec.has_imm = long_fmt && ir[12];
    dec.scale   = ir[11];
    dec.wback   = 1'b0;
    dec.op      = OP_BAD;
    if (!long_fmt) begin
      case (sop)
        SOP_ORI:  dec.op = OP_ORS;
        SOP_BCLR: dec.op = OP_BCLR;
        default:  dec.op = OP_BAD;
      endcase
    end else begin
      case (lop)
        LOP_ORI:  dec.op = OP_ORL;
        LOP_LDH,
        LOP_LDHW: begin
          dec.op    = OP_LDH;
          dec.wback = ir[15] && (ir[26:22] != '0);
        end
        LOP_JAL:  dec.op = OP_JAL;
        default:  dec.op = OP_BAD;
      endcase
    end
  end

endmodule

// File: rtl/core_exec.sv
module core_exec
  import core_pkg::*;
(
  input  dec_t            dec,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] fptr,
  input  logic [XLEN-1:0] imm32,
  input  logic [XLEN-1:0] rs_val,
  output logic            wr_en,
  output logic [RIDX-1:0] wr_idx,
  output logic [XLEN-1:0] wr_val,
  output logic            redirect,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] ea
);

  logic            alias_link;
  logic [XLEN-1:0] jal_base;

  assign alias_link = (dec.rd == dec.rs) && (dec.rd != '0);
  assign jal_base   = alias_link ? fptr : rs_val;

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = dec.rd;
    wr_val   = '0;
    redirect = 1'b0;
    target   = '0;
    ea       = '0;
    case (dec.op)
      OP_ORS: begin
        wr_en  = 1'b1;
        wr_val = rs_val | zext15(dec.imm15);
      end
      OP_ORL: begin
        wr_en  = 1'b1;
        wr_val = rs_val | imm32;
      end
      OP_BCLR: begin
        redirect = ~rs_val[dec.rd];
        target   = branch_dest(pc, dec.imm15);
      end
      OP_LDH: begin
        ea = load_ea(rs_val, imm32, dec.scale);
      end
      OP_JAL: begin
        wr_en    = 1'b1;
        wr_val   = fptr;
        redirect = 1'b1;
        target   = jal_base + imm32;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mini_risc_core.sv
module mini_risc_core
  import core_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_valid,
  input  logic [31:0] mem_rdata,
  output logic        illegal
);

  state_t          state_q;
  logic [XLEN-1:0] pc_q, fptr_q, ir_q, imm_q, ea_q;
  logic            illegal_q;

  dec_t            dec;
  logic [RIDX-1:0] rf_raddr;
  logic [XLEN-1:0] rf_rdata;
  logic            rf_we;
  logic [RIDX-1:0] rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  logic            ex_wr_en;
  logic [RIDX-1:0] ex_wr_idx;
  logic [XLEN-1:0] ex_wr_val;
  logic            ex_redirect;
  logic [XLEN-1:0] ex_target;
  logic [XLEN-1:0] ex_ea;

  // named events for the checker
  logic in_exec, in_wait, jal_fire, br_taken, ld_keep_base;

  assign in_exec      = (state_q == S_EXEC);
  assign in_wait      = (state_q == S_IWAIT) || (state_q == S_IMMWAIT) || (state_q == S_LDWAIT);
  assign jal_fire     = in_exec && (dec.op == OP_JAL);
  assign br_taken     = in_exec && (dec.op == OP_BCLR) && ex_redirect;
  assign ld_keep_base = dec.wback && (dec.rd == dec.rs);

  core_decode u_dec (
    .ir  (ir_q),
    .dec (dec)
  );

  assign rf_raddr = dec.rs;

  core_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .raddr (rf_raddr),
    .rdata (rf_rdata),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata)
  );

  core_exec u_ex (
    .dec      (dec),
    .pc       (pc_q),
    .fptr     (fptr_q),
    .imm32    (imm_q),
    .rs_val   (rf_rdata),
    .wr_en    (ex_wr_en),
    .wr_idx   (ex_wr_idx),
    .wr_val   (ex_wr_val),
    .redirect (ex_redirect),
    .target   (ex_target),
    .ea       (ex_ea)
  );

  // register write port steering
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = ex_wr_idx;
    rf_wdata = ex_wr_val;
    case (state_q)
      S_EXEC: rf_we = ex_wr_en;
      S_LDWAIT: begin
        rf_we    = mem_valid && !ld_keep_base;
        rf_waddr = dec.rd;
        rf_wdata = half_pick(mem_rdata, ea_q[1]);
      end
      S_LDWB: begin
        rf_we    = 1'b1;
        rf_waddr = dec.rs;
        rf_wdata = ea_q;
      end
      default: ;
    endcase
  end

  assign mem_req  = (state_q == S_FETCH) || (state_q == S_IMMREQ) || (state_q == S_LDREQ);
  assign mem_addr = (state_q == S_LDREQ) ? ea_q : fptr_q;
  assign illegal  = illegal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_FETCH;
      pc_q      <= RESET_VEC;
      fptr_q    <= RESET_VEC;
      ir_q      <= '0;
      imm_q     <= '0;
      ea_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      case (state_q)
        S_FETCH: begin
          pc_q    <= fptr_q;
          fptr_q  <= fptr_q + 32'd4;
          state_q <= S_IWAIT;
        end
        S_IWAIT: begin
          if (mem_valid) begin
            ir_q    <= mem_rdata;
            imm_q   <= '0;
            state_q <= S_DECODE;
          end
        end
        S_DECODE: begin
          if (dec.op == OP_BAD) begin
            illegal_q <= 1'b1;
            state_q   <= S_HALT;
          end else if (dec.has_imm) begin
            state_q <= S_IMMREQ;
          end else begin
            state_q <= S_EXEC;
          end
        end
        S_IMMREQ: begin
          fptr_q  <= fptr_q + 32'd4;
          state_q <= S_IMMWAIT;
        end
        S_IMMWAIT: begin
          if (mem_valid) begin
            imm_q   <= mem_rdata;
            state_q <= S_EXEC;
          end
        end
        S_EXEC: begin
          if (ex_redirect) fptr_q <= ex_target;
          if (dec.op == OP_LDH) begin
            ea_q    <= ex_ea;
            state_q <= S_LDREQ;
          end else begin
            state_q <= S_FETCH;
          end
        end
        S_LDREQ:  state_q <= S_LDWAIT;
        S_LDWAIT: begin
          if (mem_valid) state_q <= dec.wback ? S_LDWB : S_FETCH;
        end
        S_LDWB:   state_q <= S_FETCH;
        default:  state_q <= S_HALT;
      endcase
    end
  end

endmodule

// File: rtl/core_chk.sv
module core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_valid,
  input logic        illegal,
  input logic        in_wait,
  input logic [4:0]  rs_idx,
  input logic [31:0] rs_val,
  input logic        jal_fire,
  input logic        br_taken,
  input logic [31:0] redirect_to
);

  // R9
  reg0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_idx == 5'd0) |-> (rs_val == 32'd0));

  // R10
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req);

  // R11
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R11
  valid_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> in_wait);

  // R8
  jump_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jal_fire |=> (mem_req && (mem_addr == $past(redirect_to))));

  // R3
  branch_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (mem_req && (mem_addr == $past(redirect_to))));

endmodule

bind mini_risc_core core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_valid   (mem_valid),
  .illegal     (illegal),
  .in_wait     (in_wait),
  .rs_idx      (rf_raddr),
  .rs_val      (rf_rdata),
  .jal_fire    (jal_fire),
  .br_taken    (br_taken),
  .redirect_to (ex_target)
);

// File: tb/tb_mini_risc_core.sv
module tb_mini_risc_core;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_rdata;
  logic        illegal;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mem [0:127];
  logic        pending;
  logic [31:0] pend_addr;
  logic [31:0] last_addr, first_addr;
  int          req_count, proto_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  mini_risc_core dut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .illegal(illegal)
  );

  // encoders
  function automatic logic [31:0] e_ors(input int rd, input int rs, input logic [14:0] k);
    return {rd[4:0], rs[4:0], 7'h17, k};
  endfunction
  function automatic logic [31:0] e_bclr(input int b, input int rs, input logic [14:0] off);
    return {b[4:0], rs[4:0], 7'h49, off};
  endfunction
  function automatic logic [31:0] e_long(input int rd, input int rs, input logic [7:0] op,
                                         input logic sc);
    return {rd[4:0], rs[4:0], 2'b11, op, sc, 11'd0};
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return (a < 32'h200) ? mem[a[8:2]] : 32'hFFFF_FFFF;
  endfunction

  // memory model: answers one cycle after each request
  initial begin
    mem_valid = 1'b0; mem_rdata = '0; pending = 1'b0; pend_addr = '0;
    last_addr = '0; first_addr = '0; req_count = 0; proto_err = 0;
    forever begin
      @(negedge clk);
      mem_valid = 1'b0;
      if (!rst_n) begin
        pending = 1'b0; req_count = 0; proto_err = 0;
      end else begin
        if (mem_req && pending) proto_err++;
        if (pending) begin
          mem_valid = 1'b1;
          mem_rdata = rd_word(pend_addr);
          pending   = 1'b0;
        end
        if (mem_req) begin
          if (req_count == 0) first_addr = mem_addr;
          last_addr = mem_addr;
          pend_addr = mem_addr;
          pending   = 1'b1;
          req_count++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 128; i++) mem[i] = 32'hFFFF_FFFF;
    mem[96] = 32'h8001_7FFE;
    mem[97] = 32'h1234_5678;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic run_prog(output logic [31:0] last, output bit halted);
    do_reset();
    halted = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (illegal) begin
        halted = 1'b1;
        break;
      end
    end
    last = last_addr;
  endtask

  // probe jump: jal r0, rX, 0
  task automatic put_probe(input int at, input int r);
    mem[at]   = e_long(0, r, 8'h8B, 1'b0);
    mem[at+1] = 32'h0;
  endtask

  // {init, imm15, expected}
  localparam logic [78:0] VECS [6] = '{
    {32'h1234_0000, 15'h0055, 32'h1234_0055},
    {32'h8000_0000, 15'h7FFF, 32'h8000_7FFF},
    {32'hFFFF_0F00, 15'h00FF, 32'hFFFF_0FFF},
    {32'h0000_1000, 15'h4000, 32'h0000_5000},
    {32'hA5A5_A5A5, 15'h5A5A, 32'hA5A5_FFFF},
    {32'h0000_0000, 15'h0300, 32'h0000_0300}
  };

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_up();
  end

  initial begin
    logic [31:0] got;
    bit          h;
    int          cnt;

    // R1 reset state
    clear_mem();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(illegal == 1'b0, "R1 illegal low in reset", {31'd0, illegal}, 32'd0);
    mem[0] = e_long(0, 5, 8'h8B, 1'b0);
    mem[1] = 32'h400;
    run_prog(got, h);
    check(first_addr == 32'h0, "R1 first fetch at reset vector", first_addr, 32'h0);
    check(h && got == 32'h400, "R1 registers cleared", got, 32'h400);

    // R2 R5 vector table
    foreach (VECS[i]) begin
      clear_mem();
      mem[0] = e_long(1, 0, 8'h2F, 1'b0);
      mem[1] = VECS[i][78:47];
      mem[2] = e_ors(2, 1, VECS[i][46:32]);
      put_probe(3, 2);
      run_prog(got, h);
      check(h && got == VECS[i][31:0], "R2 R5 or immediate", got, VECS[i][31:0]);
    end

    // R9 write to r0 dropped
    clear_mem();
    mem[0] = e_ors(0, 0, 15'h123);
    mem[1] = e_long(0, 0, 8'h8B, 1'b0);
    mem[2] = 32'h800;
    run_prog(got, h);
    check(h && got == 32'h800, "R9 r0 stays zero", got, 32'h800);

    // R3 taken
    clear_mem();
    mem[0] = e_long(1, 0, 8'h2F, 1'b0);
    mem[1] = 32'hFFFF_FFF7;
    mem[2] = e_bclr(3, 1, 15'd4);
    mem[3] = e_long(0, 0, 8'h8B, 1'b0);
    mem[4] = 32'h700;
    mem[6] = e_long(0, 0, 8'h8B, 1'b0);
    mem[7] = 32'h600;
    run_prog(got, h);
    check(h && got == 32'h600, "R3 branch taken on clear bit", got, 32'h600);

    // R3 not taken
    mem[1] = 32'h0000_0008;
    run_prog(got, h);
    check(h && got == 32'h700, "R3 branch falls through on set bit", got, 32'h700);

    // R3 backward offset
    clear_mem();
    mem[0] = e_bclr(0, 0, 15'd3);
    mem[1] = e_long(0, 0, 8'h8B, 1'b0);
    mem[2] = 32'h900;
    mem[3] = e_bclr(5, 0, 15'h7FFE);
    run_prog(got, h);
    check(h && got == 32'h900, "R3 negative offset", got, 32'h900);

    // R4 R8 link is address after immediate
    clear_mem();
    mem[0]  = e_long(7, 0, 8'h8B, 1'b0);
    mem[1]  = 32'h40;
    mem[16] = e_long(0, 7, 8'h8B, 1'b0);
    mem[17] = 32'h1000;
    run_prog(got, h);
    check(h && got == 32'h1008, "R4 R8 link value", got, 32'h1008);

    // R8 link equals base
    clear_mem();
    mem[0]  = e_long(3, 0, 8'h2F, 1'b0);
    mem[1]  = 32'h2000;
    mem[2]  = e_long(3, 3, 8'h8B, 1'b0);
    mem[3]  = 32'h100;
    mem[68] = e_long(0, 3, 8'h8B, 1'b0);
    mem[69] = 32'h3000;
    run_prog(got, h);
    check(h && got == 32'h3010, "R8 link aliases base", got, 32'h3010);

    // R6 upper lane, no scale
    clear_mem();
    mem[0] = e_long(1, 0, 8'h2F, 1'b0);
    mem[1] = 32'h180;
    mem[2] = e_long(2, 1, 8'h43, 1'b0);
    mem[3] = 32'h0;
    put_probe(4, 2);
    run_prog(got, h);
    check(h && got == 32'hFFFF_8001, "R6 upper lane sign extend", got, 32'hFFFF_8001);

    // R6 lower lane with scaling
    mem[2] = e_long(2, 1, 8'h43, 1'b1);
    mem[3] = 32'h1;
    run_prog(got, h);
    check(h && got == 32'h0000_7FFE, "R6 scaled lower lane", got, 32'h0000_7FFE);

    // R7 writeback of address
    mem[2] = e_long(2, 1, 8'h4B, 1'b0);
    mem[3] = 32'h2;
    put_probe(4, 1);
    run_prog(got, h);
    check(h && got == 32'h182, "R7 base written back", got, 32'h182);

    // R7 no writeback for 0x43
    mem[2] = e_long(2, 1, 8'h43, 1'b0);
    run_prog(got, h);
    check(h && got == 32'h180, "R7 base kept without writeback", got, 32'h180);

    // R7 destination equals base
    mem[2] = e_long(1, 1, 8'h4B, 1'b0);
    mem[3] = 32'h4;
    run_prog(got, h);
    check(h && got == 32'h184, "R7 base wins over load data", got, 32'h184);

    // R10 undefined short opcode
    clear_mem();
    mem[0] = 32'h0000_0000;
    run_prog(got, h);
    check(h, "R10 illegal raised", {31'd0, h}, 32'd1);
    cnt = req_count;
    check(cnt == 1, "R10 one request only", cnt, 32'd1);
    repeat (20) @(negedge clk);
    check(req_count == cnt, "R10 no requests after halt", req_count, cnt);
    check(illegal == 1'b1, "R10 flag sticky", {31'd0, illegal}, 32'd1);

    // R10 undefined long opcode fetches no immediate
    mem[0] = e_long(1, 0, 8'h2E, 1'b0);
    run_prog(got, h);
    check(h && req_count == 1, "R10 long undefined", req_count, 32'd1);

    // R11 handshake discipline over the last run set
    check(proto_err == 0, "R11 no overlapping request", proto_err, 32'd0);

    finish_up();
  end

endmodule